// File: doc/BRIEF.md
# Pin Controller with Level and Edge Interrupts

This block is a register-mapped general-purpose pin controller for up to 32 pins. Software reaches it through a plain 32-bit register port made of a byte address, a write strobe, write data and combinational read data. Every access completes in the cycle it is presented. The port has no stall and no back-pressure: a write is taken on the rising clock edge while the strobe is high, and read data reflects the addressed register during the same cycle.

Each pin has a data-out bit and an enable bit that drive an external pad buffer. The pad input passes through a two-flop synchronizer, and the synchronized value is what software reads and what the interrupt logic sees. A pin can request service in two ways. A live level comparison is gated by a level mask. A rising or falling transition, selected per pin, is caught in a sticky event bit that software clears by writing a 1 to it, and that bit is gated by its own mask. All per-pin requests are ORed into one summary status bit, and a top-level enable bit turns that summary into the interrupt line.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, `pad_oe` and `pad_out` are all zero and `irq` is low.
- R2: Writing the data-out register (offset 0x44) sets `pad_out`, and writing the output-enable register (offset 0x48) sets `pad_oe`. Both take effect after the write edge and read back as written.
- R3: The input register (offset 0x40) shows `pad_in` through two flops. A pad change driven before rising edge k is still hidden after edge k and is visible after edge k+1, whatever the output-enable bits hold.
- R4: Pin i makes a level request while synchronized input bit i differs from level-polarity bit i (offset 0x50) and level-mask bit i (offset 0x54) is 1. A polarity of 1 therefore means the request is active while the pin is low.
- R5: Edge-polarity bit i (offset 0x64) set to 0 selects rising transitions and set to 1 selects falling ones. A selected transition sets event bit i (offset 0x58) one edge after it reaches the input register, which is the third rising edge after the pad change. A transition of the other direction sets nothing.
- R6: Event bits stay set until a write to offset 0x58 with a 1 in that bit position. Bits written with 0 keep their value.
- R7: If a selected transition is detected on a pin in the same cycle that software writes 1 to that pin's event bit, the bit ends up set.
- R8: Event bits latch regardless of the edge mask (offset 0x5C). Pin i makes an edge request only when event bit i and edge-mask bit i are both 1.
- R9: Bit 0 of the status register (offset 0x00) is 1 exactly while any pin has a level or edge request. Its other bits read 0, and writes to this register have no effect.
- R10: `irq` is high only while status bit 0 is 1 and bit 0 of the top mask register (offset 0x04) is 1. Only that bit of the top mask is stored and read back.
- R11: Reads of unmapped offsets (for example 0x4C, 0x60, 0xFC) return zero. Writes to the input register change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle while high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, same cycle |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Values to drive onto the pads |
| pad_oe | output | 32 | Per-pin pad drive enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the collision of a newly detected transition with a write-one-to-clear on the same event bit. The transition exists inside the block for only one cycle, three stages behind the pad. The bench changes a pad, lets exactly one further edge pass, and then places the clearing write so that it is taken on the edge where the transition is latched. A following read must show the bit still set. Other stimulus checks that a transition of the opposite direction sets no event bit, and that the top mask hides a pending request without clearing it.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int DATA_W = 32;

  localparam int OFS_STATUS  = 'h00;
  localparam int OFS_TOPMASK = 'h04;
  localparam int OFS_DIN     = 'h40;
  localparam int OFS_DOUT    = 'h44;
  localparam int OFS_OE      = 'h48;
  localparam int OFS_LPOL    = 'h50;
  localparam int OFS_LMASK   = 'h54;
  localparam int OFS_EVT     = 'h58;
  localparam int OFS_EMASK   = 'h5C;
  localparam int OFS_EPOL    = 'h64;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_TOPMASK,
    SEL_DIN,
    SEL_DOUT,
    SEL_OE,
    SEL_LPOL,
    SEL_LMASK,
    SEL_EVT,
    SEL_EMASK,
    SEL_EPOL
  } reg_sel_e;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] now,
  output logic [W-1:0] old
);
  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] chain [DEPTH];

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign now = chain[STAGES-1];
  assign old = chain[STAGES];
endmodule

// File: rtl/pin_irq_edge.sv
module pin_irq_edge #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] now,
  input  logic [NPIN-1:0] old,
  input  logic [NPIN-1:0] fall_sel,
  input  logic [NPIN-1:0] clr,
  output logic [NPIN-1:0] hit,
  output logic [NPIN-1:0] evt
);
  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
      logic rise_i, fall_i;
      assign rise_i = now[i] & ~old[i];
      assign fall_i = old[i] & ~now[i];
      assign hit[i] = fall_sel[i] ? fall_i : rise_i;

      always_ff @(posedge clk) begin
        if (rst)         evt[i] <= 1'b0;
        else if (hit[i]) evt[i] <= 1'b1;
        else if (clr[i]) evt[i] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/pin_irq_agg.sv
module pin_irq_agg #(
  parameter int NPIN = 32
) (
  input  logic [NPIN-1:0] now,
  input  logic [NPIN-1:0] lpol,
  input  logic [NPIN-1:0] lmask,
  input  logic [NPIN-1:0] evt,
  input  logic [NPIN-1:0] emask,
  input  logic            top_mask,
  output logic            status_any,
  output logic            irq
);
  logic [NPIN-1:0] lvl_req, edg_req;

  assign lvl_req    = (now ^ lpol) & lmask;
  assign edg_req    = evt & emask;
  assign status_any = (|lvl_req) | (|edg_req);
  assign irq        = status_any & top_mask;
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int AW   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NPIN-1:0]   din_s,
  input  logic [NPIN-1:0]   evt,
  input  logic              status_any,
  output logic [NPIN-1:0]   dout,
  output logic [NPIN-1:0]   oe,
  output logic [NPIN-1:0]   lpol,
  output logic [NPIN-1:0]   lmask,
  output logic [NPIN-1:0]   emask,
  output logic [NPIN-1:0]   epol,
  output logic [NPIN-1:0]   evt_clr,
  output logic              top_mask
);
  reg_sel_e        sel;
  logic [NPIN-1:0] wbits;

  assign wbits = wdata[NPIN-1:0];

  always_comb begin
    case (addr)
      AW'(OFS_STATUS):  sel = SEL_STATUS;
      AW'(OFS_TOPMASK): sel = SEL_TOPMASK;
      AW'(OFS_DIN):     sel = SEL_DIN;
      AW'(OFS_DOUT):    sel = SEL_DOUT;
      AW'(OFS_OE):      sel = SEL_OE;
      AW'(OFS_LPOL):    sel = SEL_LPOL;
      AW'(OFS_LMASK):   sel = SEL_LMASK;
      AW'(OFS_EVT):     sel = SEL_EVT;
      AW'(OFS_EMASK):   sel = SEL_EMASK;
      AW'(OFS_EPOL):    sel = SEL_EPOL;
      default:          sel = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= '0;
      oe       <= '0;
      lpol     <= '0;
      lmask    <= '0;
      emask    <= '0;
      epol     <= '0;
      top_mask <= 1'b0;
    end else if (we) begin
      case (sel)
        SEL_DOUT:    dout     <= wbits;
        SEL_OE:      oe       <= wbits;
        SEL_LPOL:    lpol     <= wbits;
        SEL_LMASK:   lmask    <= wbits;
        SEL_EMASK:   emask    <= wbits;
        SEL_EPOL:    epol     <= wbits;
        SEL_TOPMASK: top_mask <= wdata[0];
        default:     ;
      endcase
    end
  end

  assign evt_clr = (we && sel == SEL_EVT) ? wbits : '0;

  always_comb begin
    case (sel)
      SEL_STATUS:  rdata = DATA_W'(status_any);
      SEL_TOPMASK: rdata = DATA_W'(top_mask);
      SEL_DIN:     rdata = DATA_W'(din_s);
      SEL_DOUT:    rdata = DATA_W'(dout);
      SEL_OE:      rdata = DATA_W'(oe);
      SEL_LPOL:    rdata = DATA_W'(lpol);
      SEL_LMASK:   rdata = DATA_W'(lmask);
      SEL_EVT:     rdata = DATA_W'(evt);
      SEL_EMASK:   rdata = DATA_W'(emask);
      SEL_EPOL:    rdata = DATA_W'(epol);
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int NPIN        = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic              irq
);
  logic [NPIN-1:0] din_s, din_prev;
  logic [NPIN-1:0] dout, oe, lpol, lmask, emask, epol, evt_clr;
  logic [NPIN-1:0] evt, hit;
  logic            top_mask, status_any;

  pin_irq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .raw (pad_in),
    .now (din_s),
    .old (din_prev)
  );

  pin_irq_edge #(.NPIN(NPIN)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .now      (din_s),
    .old      (din_prev),
    .fall_sel (epol),
    .clr      (evt_clr),
    .hit      (hit),
    .evt      (evt)
  );

  pin_irq_agg #(.NPIN(NPIN)) u_agg (
    .now        (din_s),
    .lpol       (lpol),
    .lmask      (lmask),
    .evt        (evt),
    .emask      (emask),
    .top_mask   (top_mask),
    .status_any (status_any),
    .irq        (irq)
  );

  pin_irq_regs #(.NPIN(NPIN), .AW(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .addr       (bus_addr),
    .we         (bus_we),
    .wdata      (bus_wdata),
    .rdata      (bus_rdata),
    .din_s      (din_s),
    .evt        (evt),
    .status_any (status_any),
    .dout       (dout),
    .oe         (oe),
    .lpol       (lpol),
    .lmask      (lmask),
    .emask      (emask),
    .epol       (epol),
    .evt_clr    (evt_clr),
    .top_mask   (top_mask)
  );

  assign pad_out = dout;
  assign pad_oe  = oe;
endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk
  import pin_irq_pkg::*;
#(
  parameter int NPIN   = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [NPIN-1:0]   bus_wbits,
  input logic [NPIN-1:0]   pad_out,
  input logic [NPIN-1:0]   pad_oe,
  input logic              irq,
  input logic [NPIN-1:0]   evt,
  input logic [NPIN-1:0]   hit,
  input logic [NPIN-1:0]   din_s,
  input logic [NPIN-1:0]   lpol,
  input logic [NPIN-1:0]   lmask,
  input logic              status_any,
  input logic              top_mask
);
  logic wr_oe, wr_dout, wr_evt;
  assign wr_oe   = bus_we && (bus_addr == ADDR_W'(OFS_OE));
  assign wr_dout = bus_we && (bus_addr == ADDR_W'(OFS_DOUT));
  assign wr_evt  = bus_we && (bus_addr == ADDR_W'(OFS_EVT));

  AST_OE_TAKES_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_oe |=> (pad_oe == $past(bus_wbits))); // R2
  AST_DOUT_TAKES_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_dout |=> (pad_out == $past(bus_wbits))); // R2
  AST_LEVEL_REACHES_STATUS: assert property (@(posedge clk) disable iff (rst)
    (((din_s ^ lpol) & lmask) != '0) |-> status_any); // R4
  AST_EVT_ONLY_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    ((evt & ~$past(evt) & ~$past(hit)) == '0)); // R5
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
    !wr_evt |=> ((evt & $past(evt)) == $past(evt))); // R6
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |=> (($past(hit) & ~evt) == '0)); // R7
  AST_IRQ_NEEDS_TOPMASK: assert property (@(posedge clk) disable iff (rst)
    !top_mask |-> !irq); // R10
endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .bus_wbits  (bus_wdata[NPIN-1:0]),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .irq        (irq),
  .evt        (evt),
  .hit        (hit),
  .din_s      (din_s),
  .lpol       (lpol),
  .lmask      (lmask),
  .status_any (status_any),
  .top_mask   (top_mask)
);

// File: tb/pin_irq_ctrl_bench.sv
module pin_irq_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int NPIN  = 32;

  localparam logic [7:0] A_STATUS = 8'h00, A_TOPMASK = 8'h04, A_DIN = 8'h40,
                         A_DOUT = 8'h44, A_OE = 8'h48, A_LPOL = 8'h50,
                         A_LMASK = 8'h54, A_EVT = 8'h58, A_EMASK = 8'h5C,
                         A_EPOL = 8'h64;

  localparam int K_RD = 0, K_IRQ = 1, K_POUT = 2, K_POE = 3;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NPIN-1:0] pad_in = '0;
  logic [NPIN-1:0] pad_out, pad_oe;
  logic        irq;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pin_irq_ctrl u_pin_irq_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    push(K_RD, exp, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 8'hFC;
    end
  endtask

  task automatic chk(input int kind, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'hFC;
    push(kind, exp, tag);
  endtask

  task automatic set_pad(input logic [NPIN-1:0] v);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'hFC; pad_in = v;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          K_RD:    act = bus_rdata;
          K_IRQ:   act = {31'b0, irq};
          K_POUT:  act = pad_out;
          default: act = pad_oe;
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_P * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_STATUS, 0, "R1 status");
    rd(A_TOPMASK, 0, "R1 topmask");
    rd(A_DIN, 0, "R1 din");
    rd(A_DOUT, 0, "R1 dout");
    rd(A_OE, 0, "R1 oe");
    rd(A_LPOL, 0, "R1 lpol");
    rd(A_LMASK, 0, "R1 lmask");
    rd(A_EVT, 0, "R1 evt");
    rd(A_EMASK, 0, "R1 emask");
    rd(A_EPOL, 0, "R1 epol");
    chk(K_IRQ, 0, "R1 irq");
    chk(K_POE, 0, "R1 pad_oe");
    chk(K_POUT, 0, "R1 pad_out");

    // R2 outputs
    wr(A_DOUT, 32'hA5A5_0F0F);
    wr(A_OE, 32'h0000_FFFF);
    rd(A_DOUT, 32'hA5A5_0F0F, "R2 dout readback");
    rd(A_OE, 32'h0000_FFFF, "R2 oe readback");
    chk(K_POUT, 32'hA5A5_0F0F, "R2 pad_out");
    chk(K_POE, 32'h0000_FFFF, "R2 pad_oe");

    // R3 synchronizer latency, R5 rising events, R8 unmasked latch
    set_pad(32'h8000_0001);
    rd(A_DIN, 0, "R3 din hidden after one edge");
    rd(A_DIN, 32'h8000_0001, "R3 din after two edges");
    rd(A_EVT, 32'h8000_0001, "R5 rising events latched");
    rd(A_STATUS, 0, "R8 masked events give no status");

    // R6 write-one-to-clear
    wr(A_EVT, 32'h0);
    rd(A_EVT, 32'h8000_0001, "R6 zero write keeps events");
    wr(A_EVT, 32'h1);
    rd(A_EVT, 32'h8000_0000, "R6 clear bit0 only");
    wr(A_EVT, 32'h8000_0000);
    rd(A_EVT, 0, "R6 clear bit31");

    // R5 falling polarity, R8 mask, R10 top mask
    wr(A_EPOL, 32'h2);
    wr(A_EMASK, 32'h2);
    wr(A_TOPMASK, 32'hFFFF_FFFF);
    rd(A_TOPMASK, 32'h1, "R10 only bit0 stored");
    set_pad(32'h8000_0003);
    tick(2);
    rd(A_EVT, 0, "R5 rising ignored when falling selected");
    chk(K_IRQ, 0, "R8 no irq without event");
    set_pad(32'h8000_0001);
    tick(2);
    rd(A_EVT, 32'h2, "R5 falling event latched");
    rd(A_STATUS, 32'h1, "R8 masked event gives status");
    chk(K_IRQ, 1, "R10 irq raised");
    wr(A_TOPMASK, 32'h0);
    chk(K_IRQ, 0, "R10 irq gated by top mask");
    rd(A_STATUS, 32'h1, "R9 status kept while gated");
    wr(A_TOPMASK, 32'h1);
    chk(K_IRQ, 1, "R10 irq back");
    wr(A_EVT, 32'h2);
    rd(A_STATUS, 0, "R9 status clear after event clear");
    chk(K_IRQ, 0, "R10 irq low after clear");

    // R4 level requests
    wr(A_LMASK, 32'h4);
    set_pad(32'h8000_0005);
    tick(1);
    rd(A_STATUS, 32'h1, "R4 active-high level");
    chk(K_IRQ, 1, "R4 level irq");
    wr(A_LPOL, 32'h4);
    rd(A_STATUS, 0, "R4 active-low level, pin high");
    set_pad(32'h8000_0001);
    tick(1);
    rd(A_STATUS, 32'h1, "R4 active-low level, pin low");
    wr(A_LMASK, 32'h0);
    rd(A_STATUS, 0, "R4 level masked");
    wr(A_EVT, 32'hFFFF_FFFF);
    rd(A_EVT, 0, "R6 clear all");

    // R7 edge and clear in the same cycle
    set_pad(32'h8000_0009);
    tick(1);
    wr(A_EVT, 32'h8);
    rd(A_EVT, 32'h8, "R7 edge wins over clear");
    wr(A_EVT, 32'h8);
    rd(A_EVT, 0, "R7 later clear works");

    // R11 and R9 ignored writes, unmapped reads
    rd(8'h4C, 0, "R11 unmapped 0x4C");
    rd(8'h60, 0, "R11 unmapped 0x60");
    rd(8'hFC, 0, "R11 unmapped 0xFC");
    wr(A_DIN, 32'hFFFF_FFFF);
    rd(A_DIN, 32'h8000_0009, "R11 din write ignored");
    wr(A_STATUS, 32'hFFFF_FFFF);
    rd(A_STATUS, 0, "R9 status write ignored");
    wr(8'h4C, 32'hFFFF_FFFF);
    rd(A_DOUT, 32'hA5A5_0F0F, "R11 unmapped write harmless");

    tick(3);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule